// File: doc/BRIEF.md
# Retired Branch Trace Ring

This block keeps a short trace of the taken branches that a core has retired. Each accepted record holds the branch source address, the destination address and a flag that tells whether the predictor got the branch wrong. The records go into a ring of `DEPTH` slots. When the ring is full, the newest record overwrites the oldest one.

A record is stored only when all of these hold:
- the retire strobe is high;
- the branch was taken;
- logging is switched on;
- the core is not running secure enclave code.

Any other retired branch leaves the ring unchanged. A one-cycle clear pulse empties the ring.

Software reads the trace through a combinational read port. Index 0 is the newest record, index 1 the one before it, and so on. The slot index of the newest record is also visible on its own output. `DEPTH` must be a power of two.

Top module: `br_trace_log`

## Requirements
- R1: After reset, `top_o` is `DEPTH-1` (15) and every read index returns `rd_valid_o`=0 with all data outputs zero.
- R2: When `ret_valid_i`=1, `ret_taken_i`=1, `log_en_i`=1, `ret_secure_i`=0 and `clear_i`=0 at a rising edge, `top_o` increases by one (mod `DEPTH`) after that edge. Read index 0 then returns that branch's source, target and mispredict flag with `rd_valid_o`=1.
- R3: A retired branch with `ret_taken_i`=0 changes neither `top_o` nor any readable entry.
- R4: A branch retired with `ret_secure_i`=1 changes neither `top_o` nor any readable entry.
- R5: With `log_en_i`=0, no branch is recorded. Entries already stored stay readable and unchanged across enable toggles.
- R6: A taken branch with `ret_mispred_i`=1 is recorded, and `rd_mispred_o` reads 1 for it. A correctly predicted branch reads 0.
- R7: After `DEPTH` records, `top_o` wraps from 15 to 0. The next record overwrites the oldest one, and no valid entry is lost except by overwrite or clear.
- R8: Reading index i returns the slot at (`top_o` − i) mod `DEPTH`. Unwritten slots read as `rd_valid_o`=0 with zero data.
- R9: A `clear_i` pulse invalidates all entries and sets `top_o` to 15 after one edge. Clear takes priority over a branch accepted in the same cycle.
- R10: With `ret_valid_i`=0, no record is created, whatever the other retire inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| log_en_i | input | 1 | Logging enable |
| clear_i | input | 1 | Invalidate all entries and rewind the pointer |
| ret_valid_i | input | 1 | Branch retired this cycle |
| ret_src_pc_i | input | 48 | Branch source address |
| ret_tgt_pc_i | input | 48 | Branch destination address |
| ret_taken_i | input | 1 | Branch was taken |
| ret_mispred_i | input | 1 | Branch was mispredicted |
| ret_secure_i | input | 1 | Core is in secure enclave mode |
| rd_idx_i | input | 4 | Age index to read, 0 = newest |
| top_o | output | 4 | Slot of the newest entry |
| rd_valid_o | output | 1 | Selected entry holds a record |
| rd_src_o | output | 48 | Source address of selected entry |
| rd_tgt_o | output | 48 | Destination address of selected entry |
| rd_mispred_o | output | 1 | Mispredict flag of selected entry |

## Verification
- **Write timing:** an accepted branch or a clear takes effect at exactly one rising edge, and `top_o` and the read port show it after that edge.
- **Read timing:** the read port is purely combinational. A change of `rd_idx_i` is visible in the same cycle.
- **How the bench keeps to this:** it drives retire and control inputs just after a falling edge and updates its reference model at the rising edge. It compares `top_o` at the next falling edge. For reads, it sets `rd_idx_i` and compares one time unit later, before the next edge.

// File: rtl/br_trace_pkg.sv
package br_trace_pkg;
  localparam int unsigned PC_W = 48;

  typedef struct packed {
    logic [PC_W-1:0] src;
    logic [PC_W-1:0] tgt;
    logic            mispred;
  } br_rec_t;
endpackage

// File: rtl/br_trace_filter.sv
module br_trace_filter
  import br_trace_pkg::*;
(
  input  logic            valid_i,
  input  logic            taken_i,
  input  logic            secure_i,
  input  logic            en_i,
  input  logic [PC_W-1:0] src_i,
  input  logic [PC_W-1:0] tgt_i,
  input  logic            mispred_i,
  output logic            acc_o,
  output br_rec_t         rec_o
);
  // Secure-mode and not-taken branches never reach the ring
  assign acc_o         = valid_i & taken_i & en_i & ~secure_i;
  assign rec_o.src     = src_i;
  assign rec_o.tgt     = tgt_i;
  assign rec_o.mispred = mispred_i;
endmodule

// File: rtl/br_trace_ring.sv
module br_trace_ring
  import br_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  br_rec_t          rec_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] top_o,
  output logic [DEPTH-1:0] valid_o,
  output br_rec_t          mem_o [DEPTH]
);
  logic [IDX_W-1:0] top_q;
  logic [IDX_W-1:0] wr_ptr;
  logic [DEPTH-1:0] valid_q;
  logic             do_wr;

  assign wr_ptr = top_q + 1'b1;
  assign do_wr  = wr_en_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '1;
    else if (clr_i)  top_q <= '1;
    else if (wr_en_i) top_q <= wr_ptr;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = do_wr && (wr_ptr == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    valid_q[g] <= 1'b0;
      else if (clr_i) valid_q[g] <= 1'b0;
      else if (sel)   valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_o[g] <= '0;
      else if (sel) mem_o[g] <= rec_i;
    end
  end

  assign top_o   = top_q;
  assign valid_o = valid_q;

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> (top_q == IDX_W'($past(top_q) + 1'b1)) && valid_q[top_q]);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (valid_q == '0) && (top_q == '1));

  a_r7_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $countones(valid_q) >= $countones($past(valid_q)));
endmodule

// File: rtl/br_trace_rd.sv
module br_trace_rd
  import br_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] top_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DEPTH-1:0] valid_i,
  input  br_rec_t          mem_i [DEPTH],
  output logic             rd_valid_o,
  output br_rec_t          rd_rec_o
);
  logic [IDX_W-1:0] slot;

  // Age index counts back from the newest slot, wrapping mod DEPTH
  assign slot       = top_i - idx_i;
  assign rd_valid_o = valid_i[slot];
  assign rd_rec_o   = rd_valid_o ? mem_i[slot] : '0;
endmodule

// File: rtl/br_trace_log.sv
module br_trace_log
  import br_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             log_en_i,
  input  logic             clear_i,
  input  logic             ret_valid_i,
  input  logic [PC_W-1:0]  ret_src_pc_i,
  input  logic [PC_W-1:0]  ret_tgt_pc_i,
  input  logic             ret_taken_i,
  input  logic             ret_mispred_i,
  input  logic             ret_secure_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] top_o,
  output logic             rd_valid_o,
  output logic [PC_W-1:0]  rd_src_o,
  output logic [PC_W-1:0]  rd_tgt_o,
  output logic             rd_mispred_o
);
  logic             acc;
  br_rec_t          rec;
  logic [DEPTH-1:0] valid;
  br_rec_t          mem [DEPTH];
  br_rec_t          rd_rec;

  br_trace_filter u_filter (
    .valid_i  (ret_valid_i),
    .taken_i  (ret_taken_i),
    .secure_i (ret_secure_i),
    .en_i     (log_en_i),
    .src_i    (ret_src_pc_i),
    .tgt_i    (ret_tgt_pc_i),
    .mispred_i(ret_mispred_i),
    .acc_o    (acc),
    .rec_o    (rec)
  );

  br_trace_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(acc),
    .rec_i  (rec),
    .clr_i  (clear_i),
    .top_o  (top_o),
    .valid_o(valid),
    .mem_o  (mem)
  );

  br_trace_rd #(.DEPTH(DEPTH)) u_rd (
    .top_i     (top_o),
    .idx_i     (rd_idx_i),
    .valid_i   (valid),
    .mem_i     (mem),
    .rd_valid_o(rd_valid_o),
    .rd_rec_o  (rd_rec)
  );

  assign rd_src_o     = rd_rec.src;
  assign rd_tgt_o     = rd_rec.tgt;
  assign rd_mispred_o = rd_rec.mispred;

  a_r3_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ret_taken_i && !clear_i) |=> top_o == $past(top_o));

  a_r4_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_secure_i && !clear_i) |=> top_o == $past(top_o));

  a_r5_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!log_en_i && !clear_i) |=> top_o == $past(top_o));

  a_r10_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ret_valid_i && !clear_i) |=> top_o == $past(top_o));

  a_r8_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_src_o == '0) && (rd_tgt_o == '0) && !rd_mispred_o);
endmodule

// File: tb/sim_br_trace_log.sv
module sim_br_trace_log;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        log_en = 1'b0, clr = 1'b0;
  logic        rv = 1'b0, tk = 1'b0, mp = 1'b0, sec = 1'b0;
  logic [47:0] src = '0, tgt = '0;
  logic [3:0]  rd_idx = '0;
  logic [3:0]  top;
  logic        rd_valid, rd_mp;
  logic [47:0] rd_src, rd_tgt;

  int n_tests = 0, n_fail = 0;

  logic [47:0] m_src [D];
  logic [47:0] m_tgt [D];
  logic        m_mp  [D];
  logic        m_vld [D];
  int          m_top;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_trace_log u0 (
    .clk_i(clk), .rst_ni(rst_n), .log_en_i(log_en), .clear_i(clr),
    .ret_valid_i(rv), .ret_src_pc_i(src), .ret_tgt_pc_i(tgt),
    .ret_taken_i(tk), .ret_mispred_i(mp), .ret_secure_i(sec),
    .rd_idx_i(rd_idx), .top_o(top), .rd_valid_o(rd_valid),
    .rd_src_o(rd_src), .rd_tgt_o(rd_tgt), .rd_mispred_o(rd_mp)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin
      m_vld[i] = 0; m_src[i] = '0; m_tgt[i] = '0; m_mp[i] = 0;
    end
    m_top = D - 1;
  endtask

  function automatic bit accept(bit v, bit t, bit e, bit s);
    return v && t && e && !s;
  endfunction

  // Drive one cycle of retire/control inputs and update the model at the edge
  task automatic cyc(bit v, bit t, bit m, bit s, bit e, bit c, logic [47:0] ps, logic [47:0] pt);
    rv = v; tk = t; mp = m; sec = s; log_en = e; clr = c; src = ps; tgt = pt;
    @(posedge clk);
    if (c) model_reset();
    else if (accept(v, t, e, s)) begin
      m_top = (m_top + 1) % D;
      m_src[m_top] = ps; m_tgt[m_top] = pt; m_mp[m_top] = m; m_vld[m_top] = 1;
    end
    @(negedge clk);
    rv = 1'b0; clr = 1'b0;
  endtask

  task automatic chk_top(string req);
    chk(top == 4'(m_top), req, 64'(top), 64'(m_top));
  endtask

  task automatic chk_rd(int idx, string req);
    int s;
    logic [47:0] es, et;
    logic ev, em;
    rd_idx = 4'(idx);
    #1;
    s  = (m_top - idx + D) % D;
    ev = m_vld[s];
    es = ev ? m_src[s] : '0;
    et = ev ? m_tgt[s] : '0;
    em = ev ? m_mp[s] : 1'b0;
    chk(rd_valid == ev, {req, " valid"}, 64'(rd_valid), 64'(ev));
    chk(rd_src == es, {req, " src"}, 64'(rd_src), 64'(es));
    chk(rd_tgt == et, {req, " tgt"}, 64'(rd_tgt), 64'(et));
    chk(rd_mp == em, {req, " mispred"}, 64'(rd_mp), 64'(em));
  endtask

  function automatic logic [47:0] rpc();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_top("R1");
    for (int i = 0; i < D; i++) chk_rd(i, "R1");

    // R2: one plain taken branch
    cyc(1, 1, 0, 0, 1, 0, 48'h0000_1000_0530, 48'h0000_1000_05f4);
    chk_top("R2"); chk_rd(0, "R2"); chk_rd(1, "R8");

    // R3: not-taken ignored
    cyc(1, 0, 1, 0, 1, 0, 48'hAAAA, 48'hBBBB);
    chk_top("R3"); chk_rd(0, "R3");

    // R4: secure-mode branch ignored
    cyc(1, 1, 1, 1, 1, 0, 48'hCCCC, 48'hDDDD);
    chk_top("R4"); chk_rd(0, "R4");

    // R10: no strobe
    cyc(0, 1, 0, 0, 1, 0, 48'hEEEE, 48'hFFFF);
    chk_top("R10"); chk_rd(0, "R10");

    // R6: mispredicted taken branch is logged
    cyc(1, 1, 1, 0, 1, 0, 48'hFFFF_0000_0001, 48'h1234_5678_9ABC);
    chk_top("R6"); chk_rd(0, "R6"); chk_rd(1, "R6");

    // R5: disabled, then re-enabled, contents persist
    cyc(1, 1, 0, 0, 0, 0, 48'h5555, 48'h6666);
    chk_top("R5"); chk_rd(0, "R5");
    cyc(0, 0, 0, 0, 1, 0, '0, '0);
    chk_rd(0, "R5"); chk_rd(1, "R5");

    // R7: wrap past DEPTH entries
    for (int i = 0; i < D + 3; i++) begin
      cyc(1, 1, i[0], 0, 1, 0, rpc(), rpc());
      chk_top("R7");
    end
    for (int i = 0; i < D; i++) chk_rd(i, "R7");

    // R9: clear wins over a simultaneous accepted branch
    cyc(1, 1, 0, 0, 1, 1, 48'h7777, 48'h8888);
    chk_top("R9");
    for (int i = 0; i < D; i++) chk_rd(i, "R9");
    cyc(1, 1, 0, 0, 1, 0, 48'h9999, 48'hAAAA);
    chk_top("R9"); chk_rd(0, "R9");

    // Random mix (R2..R10)
    for (int n = 0; n < 400; n++) begin
      cyc(($urandom % 10) < 8, ($urandom % 10) < 7, $urandom % 2,
          ($urandom % 100) < 15, ($urandom % 100) < 85, ($urandom % 100) < 3,
          rpc(), rpc());
      chk_top("R2");
      chk_rd(int'($urandom % D), "R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule